// File: doc/BRIEF.md
# I2C Two-Stage Baud Generator

This block sets the bit timing of an I2C master from the system clock. A 7-bit baud setting holds two divisors. An exponential prescaler divides the clock by a power of two. A linear counter then divides the prescaler output by (M+1). Each terminal count of the linear counter is a sub-phase tick. Ten sub-phases make one SCL period. The master engine uses the tick, the phase number and two strobes to place its SCL edges and SDA changes.

The standard variant gives a sub-phase length of (M+1)·2^(N+1) clock cycles. SCL frequency is therefore Fclk / (10·(M+1)·2^(N+1)). A build parameter selects a second variant in which the prescaler divides by 2^N instead.

Software picks the divisor pair and writes it through a one-byte write port. While the generator runs, a new value waits until the current SCL period has finished, so SCL never shows a shortened pulse. A synchronous soft reset restores the power-on setting.

Top module: `i2c_baud_gen`

## Requirements
- R1: After reset, `baud_o` reads 0x44 (M=8, N=4), `phase_o` is 0, `scl_o` is high and `sub_tick_o` is low.
- R2: While `run_i` stays high in the standard variant, `sub_tick_o` pulses for one cycle every (M+1)·2^(N+1) clock cycles.
- R3: In a written byte, bits 6:3 are M (0 to 15) and bits 2:0 are N (0 to 7). Bit 7 is ignored. `baud_o` shows the setting in use, as {M, N}.
- R4: `phase_o` advances by one on each sub-phase tick, counts 0 to 9 and wraps from 9 to 0. It does not change between ticks.
- R5: `scl_o` is high during phases 0 to 4 and low during phases 5 to 9, so each half lasts five sub-phases.
- R6: `sda_go_o` pulses once per SCL period, in the tick cycle where the phase moves from 6 to 7. This is the middle of the low half.
- R7: `period_go_o` pulses once per SCL period, in the tick cycle where the phase moves from 9 to 0.
- R8: A write made while `run_i` is high is held back. It takes effect on the clock edge that ends the next `period_go_o` cycle. If several writes arrive in one period, the last one is applied.
- R9: A high `soft_rst_i` returns `baud_o` to 0x44 on the next edge. It also discards any held write and clears the counters and the phase to 0.
- R10: While `run_i` is low, the counters and the phase are held at 0, `scl_o` is high and no tick occurs. A write takes effect on the next edge.
- R11: With `ALT_EXP=1`, the sub-phase length is (M+1)·2^N cycles. M=0 with N=0 then gives a tick on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Generator enable from the master engine |
| soft_rst_i | input | 1 | Synchronous controller soft reset |
| baud_we_i | input | 1 | Write strobe for the baud byte |
| baud_wdata_i | input | 8 | Baud byte, {ignored, M[3:0], N[2:0]} |
| sub_tick_o | output | 1 | One-cycle sub-phase tick |
| phase_o | output | 4 | Current sub-phase, 0 to 9 |
| scl_o | output | 1 | SCL level, high for phases 0 to 4 |
| sda_go_o | output | 1 | Strobe for changing SDA, at the 6 to 7 step |
| period_go_o | output | 1 | End of an SCL period, at the 9 to 0 step |
| baud_o | output | 7 | Baud setting in use, {M, N} |

## Verification
The tick-spacing property counts cycles between ticks. It assumes that `run_i` and `soft_rst_i` do not toggle inside a measured interval; the counter restarts whenever either one does. The phase and hold properties assume that `soft_rst_i` is a clean single-cycle pulse, driven away from the clock edge. The stimulus changes the baud setting only while idle, or at known points inside a running period. It raises `soft_rst_i` for exactly one cycle and keeps `run_i` steady across every interval it measures.

// File: rtl/i2c_bg_pkg.sv
package i2c_bg_pkg;

  // Clock cycles per prescaler pulse: 2^(n+1) normally, 2^n in the alternate variant.
  function automatic int unsigned bg_pre_len(input int unsigned n, input bit alt);
    return alt ? (32'd1 << n) : (32'd2 << n);
  endfunction

  // Clock cycles per sub-phase for a divisor pair.
  function automatic int unsigned bg_sub_cycles(input int unsigned m, input int unsigned n,
                                                input bit alt);
    return (m + 32'd1) * bg_pre_len(n, alt);
  endfunction

endpackage

// File: rtl/i2c_bg_prescaler.sv
module i2c_bg_prescaler #(
  parameter int N_W = 3,
  parameter bit ALT = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_i,
  input  logic           run_i,
  input  logic [N_W-1:0] n_i,
  output logic           hit_o
);
  localparam int CW = (1 << N_W);
  localparam logic [CW:0] ONE = (CW+1)'(1);
  localparam logic [CW:0] TWO = (CW+1)'(2);

  logic [CW:0]   lim;
  logic [CW-1:0] cnt;

  generate
    if (ALT) begin : g_pow_n
      assign lim = ONE << n_i;
    end else begin : g_pow_n1
      assign lim = TWO << n_i;
    end
  endgenerate

  assign hit_o = run_i && ({1'b0, cnt} == (lim - ONE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr_i || !run_i)  cnt <= '0;
    else if (hit_o)            cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_bg_linear.sv
module i2c_bg_linear #(
  parameter int M_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_i,
  input  logic           run_i,
  input  logic           step_i,
  input  logic [M_W-1:0] m_i,
  output logic           hit_o
);
  logic [M_W-1:0] cnt;

  assign hit_o = step_i && (cnt == m_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr_i || !run_i)  cnt <= '0;
    else if (hit_o)            cnt <= '0;
    else if (step_i)           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_bg_phase.sv
module i2c_bg_phase #(
  parameter int PHASES = 10,
  parameter int PW     = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic          adv_i,
  output logic [PW-1:0] phase_o,
  output logic          wrap_o
);
  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  assign wrap_o = adv_i && (phase_o == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phase_o <= '0;
    else if (clr_i || !run_i)  phase_o <= '0;
    else if (wrap_o)           phase_o <= '0;
    else if (adv_i)            phase_o <= phase_o + 1'b1;
  end
endmodule

// File: rtl/i2c_baud_gen.sv
module i2c_baud_gen #(
  parameter int          M_W        = 4,
  parameter int          N_W        = 3,
  parameter int          REG_W      = 8,
  parameter int          SUBPHASES  = 10,
  parameter logic [6:0]  RESET_BAUD = 7'h44,
  parameter bit          ALT_EXP    = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         run_i,
  input  logic                         soft_rst_i,
  input  logic                         baud_we_i,
  input  logic [REG_W-1:0]             baud_wdata_i,
  output logic                         sub_tick_o,
  output logic [$clog2(SUBPHASES)-1:0] phase_o,
  output logic                         scl_o,
  output logic                         sda_go_o,
  output logic                         period_go_o,
  output logic [M_W+N_W-1:0]           baud_o
);
  localparam int BAUD_W = M_W + N_W;
  localparam int PH_W   = $clog2(SUBPHASES);
  localparam int HALF   = SUBPHASES / 2;
  localparam int LEN_W  = M_W + (1 << N_W) + 1;
  localparam logic [PH_W-1:0] HALF_PH = PH_W'(HALF);
  localparam logic [PH_W-1:0] SDA_PH  = PH_W'(HALF + HALF / 2 - 1);
  localparam logic [BAUD_W-1:0] RST_V = BAUD_W'(RESET_BAUD);

  logic [BAUD_W-1:0] baud_q, pend_q;
  logic              pend_v;
  logic              pre_hit_w, sub_tick_w, wrap_w, apply_now_w;
  logic [PH_W-1:0]   phase_w;
  logic [LEN_W-1:0]  sub_len_w;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^baud_wdata_i[REG_W-1:BAUD_W];

  // Divider chain: power-of-two prescaler, then the (M+1) counter, then the phase counter.
  i2c_bg_prescaler #(.N_W(N_W), .ALT(ALT_EXP)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr_i(soft_rst_i), .run_i(run_i),
    .n_i(baud_q[N_W-1:0]), .hit_o(pre_hit_w)
  );

  i2c_bg_linear #(.M_W(M_W)) u_lin (
    .clk(clk), .rst_n(rst_n), .clr_i(soft_rst_i), .run_i(run_i),
    .step_i(pre_hit_w), .m_i(baud_q[BAUD_W-1:N_W]), .hit_o(sub_tick_w)
  );

  i2c_bg_phase #(.PHASES(SUBPHASES), .PW(PH_W)) u_ph (
    .clk(clk), .rst_n(rst_n), .clr_i(soft_rst_i), .run_i(run_i),
    .adv_i(sub_tick_w), .phase_o(phase_w), .wrap_o(wrap_w)
  );

  // Setting changes land only where every counter is already zero.
  assign apply_now_w = !run_i || wrap_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baud_q <= RST_V;
      pend_q <= RST_V;
      pend_v <= 1'b0;
    end else if (soft_rst_i) begin
      baud_q <= RST_V;
      pend_q <= RST_V;
      pend_v <= 1'b0;
    end else if (baud_we_i && apply_now_w) begin
      baud_q <= baud_wdata_i[BAUD_W-1:0];
      pend_v <= 1'b0;
    end else if (baud_we_i) begin
      pend_q <= baud_wdata_i[BAUD_W-1:0];
      pend_v <= 1'b1;
    end else if (pend_v && apply_now_w) begin
      baud_q <= pend_q;
      pend_v <= 1'b0;
    end
  end

  // Expected sub-phase length, for the checker.
  assign sub_len_w = LEN_W'(i2c_bg_pkg::bg_sub_cycles(int'(baud_q[BAUD_W-1:N_W]),
                                                      int'(baud_q[N_W-1:0]), ALT_EXP));

  assign sub_tick_o  = sub_tick_w;
  assign phase_o     = phase_w;
  assign scl_o       = (phase_w < HALF_PH);
  assign sda_go_o    = sub_tick_w && (phase_w == SDA_PH);
  assign period_go_o = wrap_w;
  assign baud_o      = baud_q;
endmodule

// File: rtl/i2c_baud_gen_chk.sv
module i2c_baud_gen_chk #(
  parameter int          PH_W       = 4,
  parameter int          BAUD_W     = 7,
  parameter int          LEN_W      = 13,
  parameter int          SUBPHASES  = 10,
  parameter logic [6:0]  RESET_BAUD = 7'h44
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_i,
  input logic              soft_rst_i,
  input logic              sub_tick_i,
  input logic [PH_W-1:0]   phase_i,
  input logic              scl_i,
  input logic              sda_go_i,
  input logic              period_go_i,
  input logic [BAUD_W-1:0] baud_i,
  input logic [LEN_W-1:0]  sub_len_i
);
  localparam logic [PH_W-1:0] LAST = PH_W'(SUBPHASES - 1);
  localparam logic [PH_W-1:0] LOW0 = PH_W'(SUBPHASES / 2);

  logic [LEN_W-1:0] gap_cnt;
  logic             gap_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt <= '0;
      gap_ok  <= 1'b0;
    end else if (soft_rst_i || !run_i) begin
      gap_cnt <= '0;
      gap_ok  <= 1'b0;
    end else if (sub_tick_i) begin
      gap_cnt <= LEN_W'(1);
      gap_ok  <= 1'b1;
    end else begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_tick_i && gap_ok) |-> (gap_cnt == sub_len_i));

  p_phase_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    phase_i <= LAST);

  p_phase_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_tick_i && !soft_rst_i) |=>
      (phase_i == (($past(phase_i) == LAST) ? '0 : $past(phase_i) + 1'b1)));

  p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !soft_rst_i && !sub_tick_i) |=> $stable(phase_i));

  p_scl_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_i) |-> (phase_i == LOW0));

  p_sda_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sda_go_i |=> !scl_i);

  p_period_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    period_go_i |=> (phase_i == '0));

  p_baud_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !soft_rst_i && !period_go_i) |=> $stable(baud_i));

  p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_i |=> (baud_i == BAUD_W'(RESET_BAUD) && phase_i == '0));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i) |=> (phase_i == '0 && scl_i));
endmodule

bind i2c_baud_gen i2c_baud_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_i(run_i), .soft_rst_i(soft_rst_i),
  .sub_tick_i(sub_tick_w), .phase_i(phase_w), .scl_i(scl_o),
  .sda_go_i(sda_go_o), .period_go_i(wrap_w), .baud_i(baud_q),
  .sub_len_i(sub_len_w)
);

// File: tb/sim_i2c_baud_gen.sv
module sim_i2c_baud_gen;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, run0, run1, srst, we;
  logic [7:0] wdata;
  logic       tick0, scl0, sda0, pg0, tick1, scl1, sda1, pg1;
  logic [3:0] ph0, ph1;
  logic [6:0] baud0, baud1;
  int checks = 0;
  int fails  = 0;

  i2c_baud_gen u0 (
    .clk(clk), .rst_n(rst_n), .run_i(run0), .soft_rst_i(srst),
    .baud_we_i(we), .baud_wdata_i(wdata), .sub_tick_o(tick0), .phase_o(ph0),
    .scl_o(scl0), .sda_go_o(sda0), .period_go_o(pg0), .baud_o(baud0)
  );

  i2c_baud_gen #(.ALT_EXP(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .run_i(run1), .soft_rst_i(srst),
    .baud_we_i(we), .baud_wdata_i(wdata), .sub_tick_o(tick1), .phase_o(ph1),
    .scl_o(scl1), .sda_go_o(sda1), .period_go_o(pg1), .baud_o(baud1)
  );

  // Stimulus byte, expected setting, expected sub-phase length.
  localparam logic [7:0]  VEC_W [6] = '{8'h00, 8'h07, 8'h78, 8'h1A, 8'h44, 8'hC9};
  localparam logic [6:0]  VEC_B [6] = '{7'h00, 7'h07, 7'h78, 7'h1A, 7'h44, 7'h49};
  localparam int          VEC_L [6] = '{2, 256, 32, 32, 288, 40};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick0(output int cyc);
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!tick0 && cyc < 60000);
  endtask

  task automatic wait_tick1(output int cyc);
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!tick1 && cyc < 60000);
  endtask

  task automatic write_byte(input logic [7:0] v);
    we = 1'b1; wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic measure_period0(input int exp_len, input string tag);
    int cyc, bad_int, last_int, high, sda_n, sda_ph, pg_n, pg_ph, bad_seq, prev;
    bad_int = 0; last_int = 0; high = 0; sda_n = 0; sda_ph = -1;
    pg_n = 0; pg_ph = -1; bad_seq = 0;
    wait_tick0(cyc);
    prev = int'(ph0);
    for (int k = 0; k < 10; k++) begin
      cyc = 0;
      do begin
        @(negedge clk); cyc++;
        if (scl0) high++;
        if (sda0) begin sda_n++; sda_ph = int'(ph0); end
        if (pg0)  begin pg_n++;  pg_ph  = int'(ph0); end
      end while (!tick0 && cyc < 60000);
      if (int'(ph0) != (prev + 1) % 10) bad_seq++;
      prev = int'(ph0);
      last_int = cyc;
      if (cyc != exp_len) bad_int++;
    end
    chk(bad_int == 0, {"R2 tick spacing ", tag}, last_int, exp_len);
    chk(bad_seq == 0, {"R4 phase order ", tag}, bad_seq, 0);
    chk(high == 5 * exp_len, {"R5 scl high cycles ", tag}, high, 5 * exp_len);
    chk(sda_n == 1 && sda_ph == 6, {"R6 sda strobe phase ", tag}, sda_ph, 6);
    chk(pg_n == 1 && pg_ph == 9, {"R7 period strobe phase ", tag}, pg_ph, 9);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cyc, ticks, nz;
    rst_n = 1'b0; run0 = 1'b0; run1 = 1'b0; srst = 1'b0; we = 1'b0; wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(baud0 == 7'h44, "R1 reset baud", int'(baud0), 'h44);
    chk(ph0 == 4'd0 && scl0 && !tick0, "R1 reset phase/scl", int'(ph0), 0);

    // R10 idle: nothing moves while run is low
    ticks = 0; nz = 0;
    repeat (200) begin
      @(negedge clk);
      if (tick0) ticks++;
      if (ph0 != 4'd0 || !scl0) nz++;
    end
    chk(ticks == 0 && nz == 0, "R10 idle holds", ticks + nz, 0);

    // Table walk: R2..R7, with R3 field and bit-7 handling
    for (int i = 0; i < 6; i++) begin
      run0 = 1'b0;
      @(negedge clk);
      write_byte(VEC_W[i]);
      chk(baud0 == VEC_B[i], "R3 R10 field decode", int'(baud0), int'(VEC_B[i]));
      run0 = 1'b1;
      measure_period0(VEC_L[i], $sformatf("vec%0d", i));
    end

    // R10 stopping mid-period clears the phase
    run0 = 1'b0; @(negedge clk);
    write_byte(8'h00);
    run0 = 1'b1;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (ph0 != 4'd3 && cyc < 1000);
    run0 = 1'b0;
    @(negedge clk);
    chk(ph0 == 4'd0 && scl0, "R10 stop clears phase", int'(ph0), 0);

    // R8 deferred write, last write of the period wins
    write_byte(8'h1A);
    run0 = 1'b1;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!pg0 && cyc < 5000);
    @(negedge clk);
    write_byte(8'h07);
    write_byte(8'h00);
    chk(baud0 == 7'h1A, "R8 write held while running", int'(baud0), 'h1A);
    wait_tick0(cyc);
    wait_tick0(cyc);
    chk(cyc == 32, "R8 old spacing kept", cyc, 32);
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!pg0 && cyc < 5000);
    chk(baud0 == 7'h1A, "R8 still old at boundary cycle", int'(baud0), 'h1A);
    @(negedge clk);
    chk(baud0 == 7'h00, "R8 last write applied after boundary", int'(baud0), 'h00);
    wait_tick0(cyc);
    wait_tick0(cyc);
    chk(cyc == 2, "R8 R2 new spacing", cyc, 2);

    // R9 soft reset drops a held write
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!pg0 && cyc < 100);
    @(negedge clk);
    write_byte(8'h07);
    @(negedge clk);
    srst = 1'b1;
    @(negedge clk);
    srst = 1'b0;
    chk(baud0 == 7'h44 && ph0 == 4'd0, "R9 soft reset state", int'(baud0), 'h44);
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!pg0 && cyc < 10000);
    @(negedge clk);
    chk(baud0 == 7'h44, "R9 held write discarded", int'(baud0), 'h44);
    wait_tick0(cyc);
    wait_tick0(cyc);
    chk(cyc == 288, "R9 R2 reset spacing", cyc, 288);
    run0 = 1'b0;
    @(negedge clk);

    // R11 alternate exponent variant
    write_byte(8'h0B);
    chk(baud1 == 7'h0B, "R11 alt setting", int'(baud1), 'h0B);
    run1 = 1'b1;
    wait_tick1(cyc);
    wait_tick1(cyc);
    chk(cyc == 16, "R11 alt spacing M=1 N=3", cyc, 16);
    run1 = 1'b0; @(negedge clk);
    write_byte(8'h07);
    run1 = 1'b1;
    wait_tick1(cyc);
    wait_tick1(cyc);
    chk(cyc == 128, "R11 alt spacing M=0 N=7", cyc, 128);
    run1 = 1'b0; @(negedge clk);
    write_byte(8'h00);
    run1 = 1'b1;
    wait_tick1(cyc);
    ticks = 0;
    repeat (20) begin @(negedge clk); if (tick1) ticks++; end
    chk(ticks == 20, "R11 alt tick every cycle", ticks, 20);
    run1 = 1'b0;
    @(negedge clk);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule